// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a bank of general-purpose I/O lines placed behind a small word-addressed register bus. Software writes a data word to drive the output lines and reads the same offset to sample the input lines. Every line is driven and sampled with no direction control: a line becomes an output simply because the driven value is the wanted one. The number of lines equals the register width.

When the build includes them, two extra write-only registers let software raise or lower chosen lines in a single write, with no read-modify-write of the data word. A bit of 1 in the written word selects a line and a bit of 0 leaves it alone. A build option reverses the numbering, so that line 0 sits in the most significant register bit. This suits software that counts bits from the top of the word.

Inputs pass through a two-flop synchroniser. Read data is registered and appears one cycle after the address is presented.

Top module: `gpio_regbank`

## Requirements
- R1: WIDTH is 8, 16, 32 or 64, and the block has exactly WIDTH output lines and WIDTH input lines.
- R2: A write to word offset 0 loads the full written word into the output latch, and the lines show it after the same rising edge.
- R3: A read of offset 0 returns the input lines after a two-flop synchroniser, and read data is registered. A change on the inputs therefore appears on read data after the third rising edge following it and not after the second.
- R4: When set/clear support is built in (HAS_SETCLR=1), a write to offset 1 drives high every line whose written bit is 1 and leaves the other lines unchanged.
- R5: When HAS_SETCLR=1, a write to offset 2 drives low every line whose written bit is 1 and leaves the other lines unchanged.
- R6: Reads of offsets 1, 2 and 3 return zero, and writes to offset 3 leave the output lines unchanged.
- R7: When HAS_SETCLR=0, writes to offsets 1 and 2 leave the output lines unchanged.
- R8: With REVERSE=1, line n corresponds to register bit WIDTH-1-n for both writes and reads. With REVERSE=0, line n corresponds to bit n.
- R9: Synchronous active-high reset clears the output latch, the synchroniser and the read data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word offset: 0 data, 1 set, 2 clear |
| bus_we | input | 1 | Write strobe for the current offset |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_rdata | output | WIDTH | Registered read data for the previous cycle's offset |
| gpio_in | input | WIDTH | Input lines, indexed by line number |
| gpio_out | output | WIDTH | Output lines, indexed by line number |

## Verification
The bench drives set and clear words that contain both ones and zeros and checks that unselected lines hold their value. A design that treated these registers as plain data loads would wipe those lines. It checks the exact synchroniser latency one edge short of and at the promised edge, which catches a missing or an extra flop. A reversed build and a build without set/clear sit beside the normal one. They catch a mapping applied in only one direction, and offsets 1 and 2 wrongly decoded when their registers are absent. Offsets other than 0 are read and offset 3 is written, which exposes a read mux that leaks data or a decoder that ignores the top address bit.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFF_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_SET  = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 2'd2;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_DATA = 2'd1,
    WK_SET  = 2'd2,
    WK_CLR  = 2'd3
  } wr_kind_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
  parameter int WIDTH = 32,
  parameter bit REVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  output logic [WIDTH-1:0] y
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (REVERSE) begin : g_rev
        assign y[i] = a[WIDTH-1-i];
      end else begin : g_fwd
        assign y[i] = a[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_kind_t         wr_kind,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else begin
      case (wr_kind)
        WK_DATA: latch_q <= wr_data;
        WK_SET:  latch_q <= latch_q | wr_data;
        WK_CLR:  latch_q <= latch_q & ~wr_data;
        default: latch_q <= latch_q;
      endcase
    end
  end

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WK_DATA) |=> (latch_q == $past(wr_data))); // R2
  AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WK_SET) |=> ((($past(latch_q) & ~latch_q) == '0) && ((latch_q & $past(wr_data)) == $past(wr_data)))); // R4
  AST_CLR_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WK_CLR) |=> (((latch_q & ~$past(latch_q)) == '0) && ((latch_q & $past(wr_data)) == '0))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WK_NONE) |=> $stable(latch_q)); // R6
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter bit HAS_SETCLR = 1'b1,
  parameter bit REVERSE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  gpio_in,
  output logic [WIDTH-1:0]  gpio_out
);
  localparam int SYNC_STAGES = 2;

  initial begin
    AST_WIDTH_LEGAL: assert (WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64); // R1
  end

  wr_kind_t         wr_kind;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] in_synced;
  logic [WIDTH-1:0] in_regview;

  always_comb begin
    wr_kind = WK_NONE;
    if (bus_we) begin
      if (bus_addr == OFF_DATA) wr_kind = WK_DATA;
      else if (HAS_SETCLR && bus_addr == OFF_SET) wr_kind = WK_SET;
      else if (HAS_SETCLR && bus_addr == OFF_CLR) wr_kind = WK_CLR;
    end
  end

  gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .wr_kind(wr_kind), .wr_data(bus_wdata), .latch_q(latch_q)
  );

  gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_out_order (
    .a(latch_q), .y(gpio_out)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(gpio_in), .q(in_synced)
  );

  gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_in_order (
    .a(in_synced), .y(in_regview)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_addr == OFF_DATA) bus_rdata <= in_regview;
    else bus_rdata <= '0;
  end

  AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != OFF_DATA) |=> (bus_rdata == '0)); // R6
  AST_NO_SETCLR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!HAS_SETCLR && bus_we && bus_addr != OFF_DATA) |=> $stable(gpio_out)); // R7
endmodule

// File: tb/gpio_regbank_bench.sv
module gpio_regbank_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   bus_addr = 2'd0;
  logic         we_n = 1'b0, we_r = 1'b0, we_p = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] gpio_in = '0;
  logic [W-1:0] rd_n, rd_r, rd_p, out_n, out_r, out_p;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_regbank #(.WIDTH(W), .HAS_SETCLR(1'b1), .REVERSE(1'b0)) u_gpio_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(we_n), .bus_wdata(bus_wdata),
    .bus_rdata(rd_n), .gpio_in(gpio_in), .gpio_out(out_n));
  gpio_regbank #(.WIDTH(W), .HAS_SETCLR(1'b1), .REVERSE(1'b1)) u_gpio_regbank_rev (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(we_r), .bus_wdata(bus_wdata),
    .bus_rdata(rd_r), .gpio_in(gpio_in), .gpio_out(out_r));
  gpio_regbank #(.WIDTH(W), .HAS_SETCLR(1'b0), .REVERSE(1'b0)) u_gpio_regbank_plain (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(we_p), .bus_wdata(bus_wdata),
    .bus_rdata(rd_p), .gpio_in(gpio_in), .gpio_out(out_p));

  typedef struct packed {
    logic [1:0]   addr;
    logic [W-1:0] wd;
    logic [W-1:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 8'hA5, 8'hA5},  // R2 full load
    '{2'd1, 8'h0F, 8'hAF},  // R4 set low nibble
    '{2'd2, 8'hA0, 8'h0F},  // R5 clear high ones
    '{2'd1, 8'h00, 8'h0F},  // R4 set nothing
    '{2'd2, 8'h00, 8'h0F},  // R5 clear nothing
    '{2'd3, 8'hFF, 8'h0F},  // R6 offset 3 ignored
    '{2'd0, 8'h3C, 8'h3C},  // R2 reload
    '{2'd2, 8'hFF, 8'h00}   // R5 clear all
  };

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // sel: 0 normal, 1 reversed, 2 plain
  task automatic wr(int sel, logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    we_n = (sel == 0); we_r = (sel == 1); we_p = (sel == 2);
    @(negedge clk);
    we_n = 1'b0; we_r = 1'b0; we_p = 1'b0;
  endtask

  task automatic rd(logic [1:0] a);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset out", out_n, 8'h00);
    check("R9 reset rdata", rd_n, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R9 out after reset", out_n, 8'h00);
    check("R1 line count", W[7:0], 8'd8);

    for (int i = 0; i < 8; i++) begin
      wr(0, VECS[i].addr, VECS[i].wd);
      check($sformatf("R2/R4/R5/R6 vector %0d", i), out_n, VECS[i].exp);
    end

    // R3 synchroniser latency
    @(negedge clk);
    bus_addr = 2'd0;
    repeat (4) @(negedge clk);
    gpio_in = 8'h5A;
    @(negedge clk);
    @(negedge clk);
    check("R3 not yet visible after two edges", rd_n, 8'h00);
    @(negedge clk);
    check("R3 visible after three edges", rd_n, 8'h5A);

    // R6 reads of other offsets
    rd(2'd1); check("R6 read offset 1", rd_n, 8'h00);
    rd(2'd2); check("R6 read offset 2", rd_n, 8'h00);
    rd(2'd3); check("R6 read offset 3", rd_n, 8'h00);

    // R8 reversed mapping
    wr(1, 2'd0, 8'h01);
    check("R8 reversed write bit0 -> line7", out_r, 8'h80);
    wr(1, 2'd1, 8'h02);
    check("R8 reversed set bit1 -> line6", out_r, 8'hC0);
    wr(1, 2'd2, 8'h01);
    check("R8 reversed clear bit0", out_r, 8'h40);
    check("R8 normal unaffected", out_n, 8'h00);
    gpio_in = 8'h01;
    repeat (4) @(negedge clk);
    rd(2'd0);
    check("R8 reversed read line0 -> bit7", rd_r, 8'h80);
    check("R8 normal read line0 -> bit0", rd_n, 8'h01);

    // R7 no set/clear build
    wr(2, 2'd0, 8'h11);
    check("R7 plain data load", out_p, 8'h11);
    wr(2, 2'd1, 8'hFF);
    check("R7 plain set ignored", out_p, 8'h11);
    wr(2, 2'd2, 8'hFF);
    check("R7 plain clear ignored", out_p, 8'h11);
    rd(2'd1);
    check("R7 plain read offset 1", rd_p, 8'h00);

    // R9 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears latch", out_n, 8'h00);
    check("R9 reset clears reversed", out_r, 8'h00);
    check("R9 reset clears rdata", rd_n, 8'h00);
    rst = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule